// File: doc/BRIEF.md
# Privilege-Banked Instruction Mode Register

This block stores the mode-switch bits that an instruction decoder applies to give existing opcodes another meaning. Examples are byte order, strict floating-point conformance, or a narrower floating-point width. There is one mode register for each privilege level: user, supervisor and hypervisor. The decoder always sees the mode of the level that is running now, so a mode set by user code never changes how kernel or hypervisor code is decoded.

Software at a higher level can read and write the user register without changing its own decoding. This lets it save and restore a user context across a switch. A mode can also be armed with a countdown of retired instructions. When the countdown runs out, the mode clears itself, and no explicit switch-off instruction is needed. The 16-bit mode field is treated as opaque here: the decoder splits it into single enable bits and multi-bit selectors, and the block stores and clears it as one unit.

Top module: `modeBank`

## Requirements
- R1: There are three independent registers. A write that targets one level's register never changes `modeOut` while a different level is current.
- R2: `modeOut` is the mode field of the register of the current level. `priv` codes: 0 = user, 1 = supervisor, 2 = hypervisor, and 3 is treated as user.
- R3: Register layout: bits [15:0] hold the mode field and bits [31:16] hold the countdown. When `acsEn` is high and the access is permitted, `acsRdata` shows the live contents of register `acsIdx` in the same cycle.
- R4: Supervisor and hypervisor code can read and write the user register (`acsIdx` = 0), and doing so does not change their own `modeOut`.
- R5: An access is permitted only when `acsIdx` is 0..2 and `acsIdx` is not above the current level. A write that is not permitted changes no register, and a read that is not permitted returns 0.
- R6: Every access that is not permitted raises `illegalAccess` for exactly the cycle that follows it.
- R7: On each `retire` strobe, only the countdown of the current level's register decrements, and only if it is non-zero.
- R8: When a countdown steps from 1 to 0, the mode field of that register clears on the same edge. A countdown of 0 never expires.
- R9: If a permitted write and a countdown step hit the same register in the same cycle, the written value is stored.
- R10: A synchronous reset clears every register and `illegalAccess`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| priv | input | 2 | Current privilege level |
| acsEn | input | 1 | Register access this cycle |
| acsWe | input | 1 | Access is a write |
| acsIdx | input | 2 | Target register (0 user, 1 supervisor, 2 hypervisor) |
| acsWdata | input | 32 | Write data: {countdown, mode} |
| retire | input | 1 | One instruction retired |
| acsRdata | output | 32 | Read data: {countdown, mode}, or 0 when the access is denied |
| modeOut | output | 16 | Effective mode for the decoder |
| illegalAccess | output | 1 | One-cycle pulse after a denied access |

## Verification
Read data and `modeOut` are combinational, so they are sampled 1 ns after the inputs change at the falling edge, before any rising edge can move them. A write, a countdown step or an expiry lands on the next rising edge and is checked at the falling edge that follows. `illegalAccess` comes from a register, so it is checked one full cycle after the denied access. The countdown sequences count every retire strobe, so the cycle in which each expiry or non-expiry is expected is known exactly.

// File: rtl/modeBankPkg.sv
package modeBankPkg;
  localparam int LVL_NUM = 3;
  localparam logic [1:0] LVL_USER  = 2'd0;
  localparam logic [1:0] LVL_SUPER = 2'd1;
  localparam logic [1:0] LVL_HYPER = 2'd2;

  typedef struct packed {
    logic [LVL_NUM-1:0] wrSel;
    logic [LVL_NUM-1:0] tickSel;
  } bankStrobe_t;
endpackage

// File: rtl/modeCtrl.sv
module modeCtrl
  import modeBankPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  priv,
  input  logic        acsEn,
  input  logic        acsWe,
  input  logic [1:0]  acsIdx,
  input  logic        retire,
  output bankStrobe_t strobe,
  output logic        allowed,
  output logic [1:0]  curLvl,
  output logic        illegalAccess
);
  // reserved privilege code falls back to least privilege
  assign curLvl  = (priv == 2'd3) ? LVL_USER : priv;
  assign allowed = (acsIdx != 2'd3) && (acsIdx <= curLvl);

  for (genvar i = 0; i < LVL_NUM; i++) begin : g_sel
    assign strobe.wrSel[i]   = acsEn && acsWe && allowed && (acsIdx == 2'(i));
    assign strobe.tickSel[i] = retire && (curLvl == 2'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) illegalAccess <= 1'b0;
    else     illegalAccess <= acsEn && !allowed;
  end
endmodule

// File: rtl/modeRegs.sv
module modeRegs
  import modeBankPkg::*;
#(
  parameter int MODE_W = 16,
  parameter int CNT_W  = 16,
  localparam int REG_W = MODE_W + CNT_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  bankStrobe_t                       strobe,
  input  logic [REG_W-1:0]                  wrData,
  output logic [LVL_NUM-1:0][MODE_W-1:0]    modeQ,
  output logic [LVL_NUM-1:0][CNT_W-1:0]     cntQ
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  for (genvar i = 0; i < LVL_NUM; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        modeQ[i] <= '0;
        cntQ[i]  <= '0;
      end else if (strobe.wrSel[i]) begin
        // a write overrides a simultaneous tick or expiry
        modeQ[i] <= wrData[MODE_W-1:0];
        cntQ[i]  <= wrData[REG_W-1:MODE_W];
      end else if (strobe.tickSel[i] && (cntQ[i] != '0)) begin
        cntQ[i] <= cntQ[i] - CNT_ONE;
        if (cntQ[i] == CNT_ONE) modeQ[i] <= '0;
      end
    end
  end
endmodule

// File: rtl/modeBank.sv
module modeBank
  import modeBankPkg::*;
#(
  parameter int MODE_W = 16,
  parameter int CNT_W  = 16,
  localparam int REG_W = MODE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        priv,
  input  logic              acsEn,
  input  logic              acsWe,
  input  logic [1:0]        acsIdx,
  input  logic [REG_W-1:0]  acsWdata,
  input  logic              retire,
  output logic [REG_W-1:0]  acsRdata,
  output logic [MODE_W-1:0] modeOut,
  output logic              illegalAccess
);
  bankStrobe_t                    strobe;
  logic                           allowed;
  logic [1:0]                     curLvl;
  logic [LVL_NUM-1:0][MODE_W-1:0] modeQ;
  logic [LVL_NUM-1:0][CNT_W-1:0]  cntQ;

  modeCtrl u_ctrl (
    .clk(clk), .rst(rst), .priv(priv), .acsEn(acsEn), .acsWe(acsWe),
    .acsIdx(acsIdx), .retire(retire), .strobe(strobe), .allowed(allowed),
    .curLvl(curLvl), .illegalAccess(illegalAccess)
  );

  modeRegs #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(acsWdata),
    .modeQ(modeQ), .cntQ(cntQ)
  );

  always_comb begin
    acsRdata = '0;
    modeOut  = '0;
    for (int i = 0; i < LVL_NUM; i++) begin
      if (acsEn && allowed && (acsIdx == 2'(i))) acsRdata = {cntQ[i], modeQ[i]};
      if (curLvl == 2'(i)) modeOut = modeQ[i];
    end
  end
endmodule

// File: rtl/modeBankChk.sv
module modeBankChk #(
  parameter int MODE_W = 16,
  parameter int CNT_W  = 16,
  localparam int REG_W = MODE_W + CNT_W
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        priv,
  input logic              acsEn,
  input logic              acsWe,
  input logic [1:0]        acsIdx,
  input logic              retire,
  input logic [REG_W-1:0]  acsRdata,
  input logic [MODE_W-1:0] modeOut,
  input logic              illegalAccess
);
  logic [1:0] lvlC;
  logic       deny;
  logic       ownWrite;
  assign lvlC     = (priv == 2'd3) ? 2'd0 : priv;
  assign deny     = acsEn && ((acsIdx == 2'd3) || (acsIdx > lvlC));
  assign ownWrite = acsEn && acsWe && (acsIdx == lvlC);

  a_r6_pulse_after_denial: assert property (@(posedge clk) disable iff (rst)
    deny |=> illegalAccess);

  a_r6_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
    illegalAccess |-> $past(deny));

  a_r5_denied_read_zero: assert property (@(posedge clk) disable iff (rst)
    deny |-> (acsRdata == '0));

  // R1 and R4: only an own-level write or a retire may move the effective mode
  a_r1_other_bank_isolated: assert property (@(posedge clk) disable iff (rst)
    (!retire && !ownWrite) |=> ((priv != $past(priv)) || $stable(modeOut)));
endmodule

bind modeBank modeBankChk #(.MODE_W(MODE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_modeBank.sv
`timescale 1ns/1ps
module tb_modeBank;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  priv;
  logic        acsEn, acsWe, retire;
  logic [1:0]  acsIdx;
  logic [31:0] acsWdata, acsRdata;
  logic [15:0] modeOut;
  logic        illegalAccess;
  int          nRun = 0, nFail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  modeBank dut (
    .clk(clk), .rst(rst), .priv(priv), .acsEn(acsEn), .acsWe(acsWe),
    .acsIdx(acsIdx), .acsWdata(acsWdata), .retire(retire),
    .acsRdata(acsRdata), .modeOut(modeOut), .illegalAccess(illegalAccess)
  );

  typedef struct packed {
    logic [1:0]  pv;
    logic        we;
    logic [1:0]  idx;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        ill;
    logic [15:0] md;
  } vec_t;

  // R5 R6 R2: access table; rd is the read value before the write lands
  localparam vec_t TBL [10] = '{
    '{2'd2, 1'b1, 2'd2, 32'h0000_00A5, 32'h0, 1'b0, 16'h00A5},
    '{2'd2, 1'b1, 2'd1, 32'h0000_0033, 32'h0, 1'b0, 16'h00A5},
    '{2'd1, 1'b1, 2'd0, 32'h0000_0F0F, 32'h0, 1'b0, 16'h0033},
    '{2'd0, 1'b1, 2'd1, 32'h0000_FFFF, 32'h0, 1'b1, 16'h0F0F},
    '{2'd0, 1'b0, 2'd0, 32'h0,         32'h0000_0F0F, 1'b0, 16'h0F0F},
    '{2'd1, 1'b1, 2'd2, 32'h0000_1234, 32'h0, 1'b1, 16'h0033},
    '{2'd1, 1'b0, 2'd1, 32'h0,         32'h0000_0033, 1'b0, 16'h0033},
    '{2'd2, 1'b0, 2'd0, 32'h0,         32'h0000_0F0F, 1'b0, 16'h00A5},
    '{2'd3, 1'b0, 2'd1, 32'h0,         32'h0,         1'b1, 16'h0F0F},
    '{2'd2, 1'b1, 2'd3, 32'h0000_7777, 32'h0,         1'b1, 16'h00A5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] p, input logic en, input logic we,
                      input logic [1:0] idx, input logic [31:0] d, input logic ret);
    @(negedge clk);
    priv = p; acsEn = en; acsWe = we; acsIdx = idx; acsWdata = d; retire = ret;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; priv = 2'd0; acsEn = 1'b0; acsWe = 1'b0; acsIdx = 2'd0;
    acsWdata = '0; retire = 1'b0;
    repeat (3) @(posedge clk);
    step(2'd2, 1'b1, 1'b0, 2'd2, 32'h0, 1'b0);
    rst = 1'b0;
    #1;
    chk("R10 reset mode", 32'(modeOut), 32'h0);
    chk("R10 reset reg", acsRdata, 32'h0);
    chk("R10 reset illegal", 32'(illegalAccess), 32'h0);

    for (int k = 0; k < 10; k++) begin
      step(TBL[k].pv, 1'b1, TBL[k].we, TBL[k].idx, TBL[k].wd, 1'b0);
      #1 chk("R5 R3 table read", acsRdata, TBL[k].rd);
      step(TBL[k].pv, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
      #1 chk("R6 table illegal", 32'(illegalAccess), 32'(TBL[k].ill));
      chk("R2 R1 table mode", 32'(modeOut), 32'(TBL[k].md));
    end

    // R8: countdown of 3 expires on third retire
    step(2'd0, 1'b1, 1'b1, 2'd0, 32'h0003_0007, 1'b0);
    step(2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    step(2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    step(2'd0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
    #1 chk("R7 live count", acsRdata, 32'h0001_0007);
    chk("R8 mode held before expiry", 32'(modeOut), 32'h7);
    step(2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    step(2'd0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
    #1 chk("R8 expired reg", acsRdata, 32'h0);
    chk("R8 expired mode", 32'(modeOut), 32'h0);

    // R7: retires at user level leave the supervisor countdown alone
    step(2'd1, 1'b1, 1'b1, 2'd1, 32'h0002_0011, 1'b0);
    for (int k = 0; k < 5; k++) step(2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    step(2'd1, 1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
    #1 chk("R7 other bank untouched", acsRdata, 32'h0002_0011);
    chk("R7 supervisor mode", 32'(modeOut), 32'h11);

    // R4: supervisor restores user context without effect on itself
    step(2'd1, 1'b1, 1'b1, 2'd0, 32'h0000_00C3, 1'b0);
    step(2'd1, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0);
    #1 chk("R4 own mode kept", 32'(modeOut), 32'h11);
    step(2'd1, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
    #1 chk("R4 user readback", acsRdata, 32'h0000_00C3);

    // R8: zero countdown never expires
    for (int k = 0; k < 4; k++) step(2'd0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1);
    step(2'd0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
    #1 chk("R8 zero count persists", acsRdata, 32'h0000_00C3);
    chk("R8 zero count mode", 32'(modeOut), 32'hC3);

    // R9: write beats an expiry in the same cycle
    step(2'd0, 1'b1, 1'b1, 2'd0, 32'h0001_0009, 1'b0);
    step(2'd0, 1'b1, 1'b1, 2'd0, 32'h0000_0042, 1'b1);
    step(2'd0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
    #1 chk("R9 write wins reg", acsRdata, 32'h0000_0042);
    chk("R9 write wins mode", 32'(modeOut), 32'h42);

    // R10: reset clears everything
    @(negedge clk); rst = 1'b1;
    step(2'd2, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
    rst = 1'b0;
    #1 chk("R10 user cleared", acsRdata, 32'h0);
    chk("R10 hyper mode cleared", 32'(modeOut), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule